// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs processor-side bus cycles on a bus whose lines carry first an address and then data. A client presents a request with a direction (read or write), an address space (memory or I/O), an address and write data. When the sequencer can take it, the request is latched, and the bus cycle then runs through four clock phases: address, strobe, sample and finish. Wait phases are added between sample and finish for as long as the slave holds its ready input low.

The sequencer produces the address latch pulse, the active-low read and write strobes, the active-low transceiver enable, the transceiver direction, the address-space select, and the drive enable for the shared lines. At the end of each cycle it presents the captured read data and raises a one-clock completion pulse. Between cycles with no pending work it sits in idle. A request offered in the finish phase starts the next cycle straight away.

Top module: `bcyc_sequencer`

## Requirements
- R1: While reset is low and in the first clock after it, the block is idle: address strobe 0, read, write and transceiver-enable strobes 1, bus drive enable 0, completion 0, request-ready 1, direction 0, space select 0.
- R2: A request with `req_valid` high while `req_ready` is high is accepted at that clock edge. In the next clock the address phase runs: `addr_strobe`=1, `bus_oe`=1, `bus_out` equals the address, `xcvr_dir` is 1 for a write and 0 for a read, and `space_io` is 1 for I/O and 0 for memory. The read, write and enable strobes stay high in this phase.
- R3: In the strobe phase (the clock after the address phase) the address strobe is 0 and `xcvr_en_n` is 0. A read pulls `rd_strb_n` low and drops `bus_oe`. A write pulls `wr_strb_n` low and drives the write data on the low DATA_W lines of `bus_out`, with the upper lines zero. The two strobes are never low together.
- R4: The sample phase follows the strobe phase. If `slave_rdy` is high at the clock edge that ends it, the finish phase comes next, so a cycle with no waits runs from the address phase to the finish phase in 4 clocks.
- R5: Each edge that ends a sample or wait phase with `slave_rdy` low adds one wait phase, and the strobes, enable and bus drive keep their strobe-phase values through it.
- R6: On a read, `rsp_rdata` takes the low DATA_W bits of `bus_in` at the edge that ends the last sample or wait phase, the one where `slave_rdy` is high. It holds that value until the next read completes. Write cycles leave it unchanged.
- R7: In the finish phase `rsp_done` is 1 for exactly one clock, and the read, write and enable strobes are all 1 with `bus_oe` 0.
- R8: `req_ready` is 1 only in idle and in the finish phase. A request accepted in the finish phase starts the next address phase on the following clock, with no idle clock in between.
- R9: `xcvr_dir` and `space_io` hold one value from the address phase through the finish phase of a cycle, and are 0 in idle.
- R10: Request fields are sampled only at acceptance. Changes on `req_write`, `req_io`, `req_addr` or `req_wdata` during a cycle have no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | ADDR_W | Cycle address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request can be accepted this clock |
| rsp_rdata | output | DATA_W | Data captured by the last read |
| rsp_done | output | 1 | One-clock completion pulse in the finish phase |
| bus_in | input | ADDR_W | Shared lines as seen from the pins |
| bus_out | output | ADDR_W | Value driven on the shared lines |
| bus_oe | output | 1 | Drive enable for the shared lines |
| slave_rdy | input | 1 | Slave ready, high to end the cycle |
| addr_strobe | output | 1 | Address latch pulse |
| rd_strb_n | output | 1 | Read strobe, active low |
| wr_strb_n | output | 1 | Write strobe, active low |
| xcvr_en_n | output | 1 | Data transceiver enable, active low |
| xcvr_dir | output | 1 | Transceiver direction, 1 = out |
| space_io | output | 1 | Address space select, 1 = I/O |

## Verification
The bench varies the number of wait phases, including zero, and checks each phase of every cycle. A design that sampled ready one phase early, or ignored it, would show a shortened or stretched cycle or a completion pulse at the wrong clock. The slave drives the inverted data on `bus_in` in every clock except the ready clock, so a read captured on the wrong clock returns the wrong value, and a write that overwrote `rsp_rdata` would be caught. Back-to-back requests taken in the finish phase show whether an idle clock slips in. The request fields are changed during each cycle, which catches any address or data that is not held.

// File: rtl/bcyc_pkg.sv
// Shared types for the bus cycle sequencer.
// Assumes: one state per clock phase of a bus cycle.
package bcyc_pkg;

    // Phases of a bus cycle plus idle
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,  // no cycle running
        ST_ADR  = 3'd1,  // address on the shared lines, latch pulse
        ST_STB  = 3'd2,  // strobe asserted, address removed
        ST_SMP  = 3'd3,  // ready sampled at the end of this phase
        ST_WT   = 3'd4,  // wait phase, repeats while ready is low
        ST_FIN  = 3'd5   // strobes released, completion pulse
    } bstate_e;

endpackage

// File: rtl/bcyc_fsm.sv
// Phase sequencer: steps idle -> address -> strobe -> sample -> (wait)* -> finish.
// Assumes: slave ready is synchronous to clk; requests may arrive in idle or finish.
module bcyc_fsm
    import bcyc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    slave_rdy,
    output bstate_e state_q,
    output logic    req_ready,
    output logic    accept,
    output logic    capture
);

    bstate_e state_d;

    // Request can be taken only when no cycle is in its active phases
    assign req_ready = (state_q == ST_IDLE) || (state_q == ST_FIN);
    assign accept    = req_valid && req_ready;
    // Read data is valid at the edge that ends the sample or wait phase with ready high
    assign capture   = ((state_q == ST_SMP) || (state_q == ST_WT)) && slave_rdy;

    // Next-phase selection
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: state_d = req_valid ? ST_ADR : ST_IDLE;
            ST_ADR:  state_d = ST_STB;
            ST_STB:  state_d = ST_SMP;
            ST_SMP:  state_d = slave_rdy ? ST_FIN : ST_WT;
            ST_WT:   state_d = slave_rdy ? ST_FIN : ST_WT;
            ST_FIN:  state_d = req_valid ? ST_ADR : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/bcyc_req_latch.sv
// Holds the accepted request for the life of a cycle and captures read data.
// Assumes: accept and capture come from the phase sequencer; DATA_W <= ADDR_W.
module bcyc_req_latch #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [ADDR_W-1:0] bus_in,
    output logic              write_q,
    output logic              io_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    // Request fields are sampled only at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            io_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            write_q <= req_write;
            io_q    <= req_io;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Read data capture on the ready edge of a read cycle
    always_ff @(posedge clk) begin
        if (!rst_n)                  rdata_q <= '0;
        else if (capture && !write_q) rdata_q <= bus_in[DATA_W-1:0];
    end

endmodule

// File: rtl/bcyc_pin_decode.sv
// Decodes the pin levels of the bus from the current phase and the held request.
// Assumes: pins are pure functions of registered state, so they change only after clock edges.
module bcyc_pin_decode
    import bcyc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  bstate_e           state_q,
    input  logic              write_q,
    input  logic              io_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    output logic              addr_strobe,
    output logic              rd_strb_n,
    output logic              wr_strb_n,
    output logic              xcvr_en_n,
    output logic              xcvr_dir,
    output logic              space_io,
    output logic [ADDR_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              rsp_done
);

    localparam int PAD_W = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] wdata_lane;
    logic              busy;
    logic              strobing;

    // Place write data on the low lines; the padding variant depends on the widths
    generate
        if (PAD_W > 0) begin : g_pad
            assign wdata_lane = {{PAD_W{1'b0}}, wdata_q};
        end else begin : g_nopad
            assign wdata_lane = wdata_q[ADDR_W-1:0];
        end
    endgenerate

    assign busy     = (state_q != ST_IDLE);
    assign strobing = (state_q == ST_STB) || (state_q == ST_SMP) || (state_q == ST_WT);

    // Pin levels per phase
    always_comb begin
        addr_strobe = (state_q == ST_ADR);
        rd_strb_n   = !(strobing && !write_q);
        wr_strb_n   = !(strobing && write_q);
        xcvr_en_n   = !strobing;
        xcvr_dir    = busy && write_q;
        space_io    = busy && io_q;
        rsp_done    = (state_q == ST_FIN);
        bus_oe      = (state_q == ST_ADR) || (strobing && write_q);
        if (state_q == ST_ADR)          bus_out = addr_q;
        else if (strobing && write_q)   bus_out = wdata_lane;
        else                            bus_out = '0;
    end

endmodule

// File: rtl/bcyc_sequencer.sv
// Top of the multiplexed bus cycle sequencer.
// Assumes: one request at a time, accepted in idle or in the finish phase;
// an external tri-state buffer uses bus_out/bus_oe and feeds back bus_in.
module bcyc_sequencer
    import bcyc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    input  logic [ADDR_W-1:0] bus_in,
    output logic [ADDR_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic              slave_rdy,
    output logic              addr_strobe,
    output logic              rd_strb_n,
    output logic              wr_strb_n,
    output logic              xcvr_en_n,
    output logic              xcvr_dir,
    output logic              space_io
);

    bstate_e           state_q;
    logic              accept;
    logic              capture;
    logic              write_q;
    logic              io_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    bcyc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .slave_rdy (slave_rdy),
        .state_q   (state_q),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture)
    );

    bcyc_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_write (req_write),
        .req_io    (req_io),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_in    (bus_in),
        .write_q   (write_q),
        .io_q      (io_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rdata_q   (rsp_rdata)
    );

    bcyc_pin_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .state_q     (state_q),
        .write_q     (write_q),
        .io_q        (io_q),
        .addr_q      (addr_q),
        .wdata_q     (wdata_q),
        .addr_strobe (addr_strobe),
        .rd_strb_n   (rd_strb_n),
        .wr_strb_n   (wr_strb_n),
        .xcvr_en_n   (xcvr_en_n),
        .xcvr_dir    (xcvr_dir),
        .space_io    (space_io),
        .bus_out     (bus_out),
        .bus_oe      (bus_oe),
        .rsp_done    (rsp_done)
    );

endmodule

// File: rtl/bcyc_sequencer_chk.sv
// Protocol checker for the bus cycle sequencer, attached to every instance by bind.
// Assumes: observes the top-level pins only.
module bcyc_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_done,
    input logic bus_oe,
    input logic slave_rdy,
    input logic addr_strobe,
    input logic rd_strb_n,
    input logic wr_strb_n,
    input logic xcvr_en_n,
    input logic xcvr_dir,
    input logic space_io
);

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_strb_n && !wr_strb_n));

    // R3
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strb_n |-> !bus_oe);

    // R2
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> addr_strobe);

    // R3
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |=> (!addr_strobe && !xcvr_en_n));

    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!rd_strb_n || !wr_strb_n) && !slave_rdy) |=> (!rd_strb_n || !wr_strb_n));

    // R7
    done_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (rd_strb_n && wr_strb_n && xcvr_en_n && !bus_oe));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R8
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xcvr_en_n |-> !req_ready);

    // R9
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xcvr_en_n |-> ($stable(xcvr_dir) && $stable(space_io)));

endmodule

bind bcyc_sequencer bcyc_sequencer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .bus_oe      (bus_oe),
    .slave_rdy   (slave_rdy),
    .addr_strobe (addr_strobe),
    .rd_strb_n   (rd_strb_n),
    .wr_strb_n   (wr_strb_n),
    .xcvr_en_n   (xcvr_en_n),
    .xcvr_dir    (xcvr_dir),
    .space_io    (space_io)
);

// File: tb/bcyc_sequencer_test.sv
// Self-checking bench: directed corner cycles plus seeded random cycles.
module bcyc_sequencer_test;

    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic          req_io = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_done;
    logic [AW-1:0] bus_in = '0;
    logic [AW-1:0] bus_out;
    logic          bus_oe;
    logic          slave_rdy = 1'b0;
    logic          addr_strobe, rd_strb_n, wr_strb_n, xcvr_en_n, xcvr_dir, space_io;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit finished = 0;
    logic [DW-1:0] last_rd = '0;

    bcyc_sequencer #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .slave_rdy(slave_rdy),
        .addr_strobe(addr_strobe), .rd_strb_n(rd_strb_n), .wr_strb_n(wr_strb_n),
        .xcvr_en_n(xcvr_en_n), .xcvr_dir(xcvr_dir), .space_io(space_io)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000 && !finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic expect_eq(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Expected {addr_strobe, rd_strb_n, wr_strb_n, xcvr_en_n, bus_oe}: 0 idle/finish, 1 address, 2 strobe/sample/wait
    function automatic logic [4:0] exp_ctl(input int ph, input bit w);
        case (ph)
            1:       return 5'b11111;
            2:       return {1'b0, w, ~w, 1'b0, w};
            default: return 5'b01110;
        endcase
    endfunction

    function automatic logic [AW-1:0] exp_wlane(input logic [DW-1:0] d);
        return {{(AW-DW){1'b0}}, d};
    endfunction

    function automatic logic [4:0] ctl();
        return {addr_strobe, rd_strb_n, wr_strb_n, xcvr_en_n, bus_oe};
    endfunction

    task automatic set_rdy(input bit r, input logic [AW-1:0] v);
        slave_rdy = r;
        bus_in = r ? v : ~v;
    endtask

    task automatic run_txn(input bit w, input bit io, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input int nwait,
                           input logic [AW-1:0] rbus, input bit b2b);
        int c_start;
        if (!b2b) begin
            @(negedge clk);
            expect_eq("R8 idle ready", req_ready, 1'b1);
            expect_eq("R8 idle pins", ctl(), exp_ctl(0, 0));
            expect_eq("R9 idle dir/space", {xcvr_dir, space_io}, 2'b00);
            expect_eq("R7 idle done", rsp_done, 1'b0);
        end else begin
            expect_eq("R8 ready in finish", req_ready, 1'b1);
        end
        req_valid = 1'b1; req_write = w; req_io = io; req_addr = a; req_wdata = d;
        @(negedge clk);
        c_start = cyc;
        // R10: disturb the request fields after acceptance
        req_valid = 1'b0; req_write = ~w; req_io = ~io;
        req_addr = AW'($urandom); req_wdata = DW'($urandom);
        expect_eq("R2 address phase pins", ctl(), exp_ctl(1, w));
        expect_eq("R2 address on bus", bus_out, a);
        expect_eq("R2 dir/space", {xcvr_dir, space_io}, {w, io});
        expect_eq("R8 busy ready", req_ready, 1'b0);
        @(negedge clk);
        expect_eq("R3 strobe phase pins", ctl(), exp_ctl(2, w));
        if (w) expect_eq("R3 R10 write data lane", bus_out, exp_wlane(d));
        expect_eq("R9 dir/space held", {xcvr_dir, space_io}, {w, io});
        @(negedge clk);
        expect_eq("R4 sample phase pins", ctl(), exp_ctl(2, w));
        expect_eq("R4 no early done", rsp_done, 1'b0);
        set_rdy(nwait == 0, rbus);
        for (int i = 0; i < nwait; i++) begin
            @(negedge clk);
            expect_eq("R5 wait phase pins", ctl(), exp_ctl(2, w));
            expect_eq("R5 no done in wait", rsp_done, 1'b0);
            if (w) expect_eq("R5 write data held", bus_out, exp_wlane(d));
            set_rdy(i == nwait - 1, rbus);
        end
        @(negedge clk);
        expect_eq("R7 finish pins", ctl(), exp_ctl(0, w));
        expect_eq("R7 done pulse", rsp_done, 1'b1);
        expect_eq("R4 cycle length", cyc - c_start, 3 + nwait);
        expect_eq("R9 dir/space in finish", {xcvr_dir, space_io}, {w, io});
        if (!w) last_rd = rbus[DW-1:0];
        expect_eq(w ? "R6 rdata kept on write" : "R6 read capture", rsp_rdata, last_rd);
        set_rdy(1'b0, AW'($urandom));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        @(negedge clk);
        @(negedge clk);
        expect_eq("R1 pins in reset", ctl(), exp_ctl(0, 0));
        expect_eq("R1 ready/done in reset", {req_ready, rsp_done, xcvr_dir, space_io}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        expect_eq("R1 pins after reset", ctl(), exp_ctl(0, 0));
        expect_eq("R1 rdata after reset", rsp_rdata, '0);

        // Directed corners
        run_txn(0, 0, 16'h1234, 8'h00, 0, 16'hBEA5, 0);
        run_txn(1, 0, 16'hFFFF, 8'hC3, 0, 16'h0000, 0);
        run_txn(0, 1, 16'h0002, 8'h00, 3, 16'h5A7E, 0);
        run_txn(1, 1, 16'h8001, 8'h7F, 2, 16'h0000, 0);
        run_txn(0, 0, 16'h4444, 8'h00, 1, 16'h00FF, 1);
        run_txn(1, 0, 16'h0000, 8'hFF, 0, 16'h0000, 1);
        run_txn(0, 1, 16'hA0A0, 8'h00, 5, 16'h9911, 1);

        // Random mix
        for (int k = 0; k < 80; k++) begin
            run_txn(1'($urandom), 1'($urandom), AW'($urandom), DW'($urandom),
                    int'($urandom_range(0, 4)), AW'($urandom), 1'($urandom));
        end

        @(negedge clk);
        expect_eq("R7 done drops", rsp_done, 1'b0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule